// File: doc/BRIEF.md
# Machine status word update unit

This unit holds the low control-register bits of a processor: protection enable (bit 0), monitor coprocessor (bit 1), emulation (bit 2) and task-switched (bit 3). The upper bits, such as paging, cache disable, alignment and write protect, live in the same register. The unit accepts two kinds of write.

A legacy status-word load takes a fixed 16-bit operand in every mode and only reaches the low four bits. A full control-register move takes a full-width operand and rewrites every bit. The legacy load can set protection enable but can never clear it. Only the full move can return the unit to real-address mode.

The legacy load is checked against the LOCK flag, the privilege level and the current mode. When a check fails, the unit reports a fault code and leaves the register untouched. A legacy load that completes emits a one-cycle serialize pulse, which the surrounding pipeline uses to drain. The drain itself is not part of this unit.

Top module: `msw_update`

## Requirements
- R1: While rst_n is low and after it is released, ctl_reg equals 32'h0000_0010 (protection enable cleared), prot_mode is 0, serialize is 0 and fault_code is 2'b00.
- R2: A legacy load (wr_en=1, wr_full=0) that completes copies src_msw[3:1] into ctl_reg[3:1]. It leaves ctl_reg[XLEN-1:4] unchanged, and src_msw[15:4] has no effect.
- R3: A completed legacy load with src_msw[0]=1 sets ctl_reg[0], and prot_mode (which mirrors ctl_reg[0]) reads 1.
- R4: A completed legacy load with src_msw[0]=0 leaves ctl_reg[0] at its previous value, so it never clears protection enable.
- R5: A full move (wr_en=1, wr_full=1) loads src_full into every bit of ctl_reg, including clearing bit 0. It raises no fault regardless of lock, cpl and mode.
- R6: mode is encoded as 0 real, 1 protected, 2 virtual-8086 and 3 64-bit. In any mode other than 0, a legacy load with cpl not equal to 0 raises general protection, with fault_code 2'b01 and error code 0. In mode 0, cpl is ignored.
- R7: A legacy load with lock=1 raises invalid opcode (fault_code 2'b10) in every mode. This fault takes priority over the privilege fault.
- R8: serialize is high for exactly the one cycle after each completed legacy load. It stays low after full moves, faults and idle cycles.
- R9: A faulting legacy load leaves ctl_reg unchanged and produces no serialize pulse.
- R10: ctl_reg, serialize and fault_code take their new values at the clock edge that samples wr_en. fault_code returns to 2'b00 on the next edge without a faulting write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write command for this cycle |
| wr_full | input | 1 | Write type: 1 for a full move, 0 for a legacy load |
| src_msw | input | 16 | Legacy load operand |
| src_full | input | XLEN | Full move operand |
| cpl | input | 2 | Current privilege level |
| mode | input | 2 | Operating mode (0 real, 1 protected, 2 virtual-8086, 3 64-bit) |
| lock | input | 1 | LOCK prefix present on the write |
| ctl_reg | output | XLEN | Control register |
| prot_mode | output | 1 | Protection enable, bit 0 of ctl_reg |
| serialize | output | 1 | One-cycle pulse after a completed legacy load |
| fault_code | output | 2 | 00 none, 01 general protection (code 0), 10 invalid opcode |

## Verification
The bench aims at the protection-enable bit first. It issues legacy loads with source bit 0 clear while the bit is set; a design that copied all four bits would drop back to real mode. It issues full moves that clear the bit; a design that made the bit sticky for every write would be stuck in protected mode.

It combines LOCK with a nonzero privilege level in protected mode to expose a wrong fault priority. It also issues nonzero privilege levels in real mode, where a design that checked privilege everywhere would fault spuriously.

Finally, it loads legacy operands with random upper bits over random upper register contents. A design that leaked the wider operand, or that touched the register or pulsed serialize on a fault, would miscompare.

// File: rtl/msw_pkg.sv
package msw_pkg;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_PROT = 2'd1,
    MODE_V86  = 2'd2,
    MODE_LONG = 2'd3
  } cpu_mode_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_UD   = 2'd2
  } fault_e;

  localparam int MSW_OPND_W = 16;
  localparam int MSW_LOAD_W = 4;

  // Fault for a legacy load: LOCK wins over privilege.
  function automatic fault_e legacy_fault(input logic lock_i,
                                          input logic [1:0] cpl_i,
                                          input cpu_mode_e mode_i);
    if (lock_i)
      return FLT_UD;
    else if (mode_i != MODE_REAL && cpl_i != 2'd0)
      return FLT_GP;
    else
      return FLT_NONE;
  endfunction

  // Low nibble after a legacy load: bit 0 may only rise.
  function automatic logic [MSW_LOAD_W-1:0] legacy_nibble(
      input logic [MSW_LOAD_W-1:0] cur_i,
      input logic [MSW_LOAD_W-1:0] src_i);
    return {src_i[MSW_LOAD_W-1:1], cur_i[0] | src_i[0]};
  endfunction

endpackage

// File: rtl/msw_fault_decode.sv
module msw_fault_decode
  import msw_pkg::*;
(
  input  logic       wr_en,
  input  logic       wr_full,
  input  logic       lock,
  input  logic [1:0] cpl,
  input  logic [1:0] mode,
  output fault_e     flt
);

  always_comb begin
    if (wr_en && !wr_full)
      flt = legacy_fault(lock, cpl, cpu_mode_e'(mode));
    else
      flt = FLT_NONE;
  end

endmodule

// File: rtl/msw_next.sv
module msw_next
  import msw_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]       cur,
  input  logic [MSW_OPND_W-1:0] src_msw,
  input  logic [XLEN-1:0]       src_full,
  input  logic                  sel_full,
  output logic [XLEN-1:0]       nxt
);

  logic [XLEN-1:0] legacy_val;

  generate
    if (XLEN > MSW_LOAD_W) begin : g_upper
      assign legacy_val = {cur[XLEN-1:MSW_LOAD_W],
                           legacy_nibble(cur[MSW_LOAD_W-1:0], src_msw[MSW_LOAD_W-1:0])};
    end else begin : g_narrow
      assign legacy_val = legacy_nibble(cur[MSW_LOAD_W-1:0], src_msw[MSW_LOAD_W-1:0]);
    end
  endgenerate

  assign nxt = sel_full ? src_full : legacy_val;

endmodule

// File: rtl/msw_update.sv
module msw_update
  import msw_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RST_VALUE = 32'h0000_0010
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_full,
  input  logic [15:0]     src_msw,
  input  logic [XLEN-1:0] src_full,
  input  logic [1:0]      cpl,
  input  logic [1:0]      mode,
  input  logic            lock,
  output logic [XLEN-1:0] ctl_reg,
  output logic            prot_mode,
  output logic            serialize,
  output logic [1:0]      fault_code
);

  // Reset always lands in real-address mode.
  localparam logic [XLEN-1:0] RST_CLEAN = RST_VALUE & ~{{(XLEN-1){1'b0}}, 1'b1};

  fault_e          flt_now;
  logic            fault_now;
  logic            accept_legacy;
  logic            accept_full;
  logic            ctl_we;
  logic [XLEN-1:0] ctl_q;
  logic [XLEN-1:0] ctl_nxt;
  logic            ser_q;
  fault_e          flt_q;

  msw_fault_decode u_dec (
    .wr_en   (wr_en),
    .wr_full (wr_full),
    .lock    (lock),
    .cpl     (cpl),
    .mode    (mode),
    .flt     (flt_now)
  );

  msw_next #(.XLEN(XLEN)) u_nxt (
    .cur      (ctl_q),
    .src_msw  (src_msw),
    .src_full (src_full),
    .sel_full (wr_full),
    .nxt      (ctl_nxt)
  );

  assign fault_now     = (flt_now != FLT_NONE);
  assign accept_legacy = wr_en && !wr_full && !fault_now;
  assign accept_full   = wr_en && wr_full;
  assign ctl_we        = accept_legacy || accept_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= RST_CLEAN;
      ser_q <= 1'b0;
      flt_q <= FLT_NONE;
    end else begin
      if (ctl_we)
        ctl_q <= ctl_nxt;
      ser_q <= accept_legacy;
      flt_q <= flt_now;
    end
  end

  assign ctl_reg    = ctl_q;
  assign prot_mode  = ctl_q[0];
  assign serialize  = ser_q;
  assign fault_code = flt_q;

endmodule

// File: rtl/msw_update_sva.sv
module msw_update_sva #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            wr_full,
  input logic            lock,
  input logic [XLEN-1:0] ctl_reg,
  input logic            prot_mode,
  input logic            serialize,
  input logic [1:0]      fault_code,
  input logic            accept_legacy,
  input logic            fault_now
);

  assert_upper_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_legacy |=> ctl_reg[XLEN-1:4] == $past(ctl_reg[XLEN-1:4]));

  assert_pe_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_legacy && prot_mode) |=> prot_mode);

  assert_lock_ud_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_full && lock) |=> fault_code == 2'd2);

  assert_ser_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    serialize |-> $past(accept_legacy));

  assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_now |=> (ctl_reg == $past(ctl_reg)) && !serialize);

  assert_fault_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> fault_code == 2'd0);

  assert_full_nofault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_full) |=> fault_code == 2'd0 && !serialize);

endmodule

bind msw_update msw_update_sva #(.XLEN(XLEN)) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .wr_full       (wr_full),
  .lock          (lock),
  .ctl_reg       (ctl_reg),
  .prot_mode     (prot_mode),
  .serialize     (serialize),
  .fault_code    (fault_code),
  .accept_legacy (accept_legacy),
  .fault_now     (fault_now)
);

// File: tb/tb_msw_update.sv
module tb_msw_update;

  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0, wr_full = 1'b0, lock = 1'b0;
  logic [15:0]     src_msw = '0;
  logic [XLEN-1:0] src_full = '0;
  logic [1:0]      cpl = '0, mode = '0;
  logic [XLEN-1:0] ctl_reg;
  logic            prot_mode, serialize;
  logic [1:0]      fault_code;

  int n_chk = 0;
  int n_bad = 0;
  logic [XLEN-1:0] model = 32'h0000_0010;

  always #4 clk = ~clk;

  msw_update dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_full(wr_full),
    .src_msw(src_msw), .src_full(src_full), .cpl(cpl), .mode(mode), .lock(lock),
    .ctl_reg(ctl_reg), .prot_mode(prot_mode), .serialize(serialize),
    .fault_code(fault_code)
  );

  // Expected fault: lock -> 10 (R7); non-real mode with cpl!=0 -> 01 (R6).
  function automatic logic [1:0] exp_fault(input logic we, input logic full,
                                           input logic lk, input logic [1:0] pl,
                                           input logic [1:0] md);
    if (!we || full) return 2'd0;
    if (lk) return 2'd2;
    if (md != 2'd0 && pl != 2'd0) return 2'd1;
    return 2'd0;
  endfunction

  // Register after a legacy load: bits 3:1 follow the operand, bit 0 only rises.
  function automatic logic [XLEN-1:0] exp_legacy(input logic [XLEN-1:0] cur,
                                                 input logic [15:0] s);
    logic [XLEN-1:0] r;
    r = cur;
    r[3:1] = s[3:1];
    if (s[0]) r[0] = 1'b1;
    return r;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic we, input logic full,
                      input logic [15:0] s16, input logic [XLEN-1:0] sf,
                      input logic [1:0] pl, input logic [1:0] md, input logic lk);
    logic [1:0] ef;
    logic       eser;
    wr_en = we; wr_full = full; src_msw = s16; src_full = sf;
    cpl = pl; mode = md; lock = lk;
    ef   = exp_fault(we, full, lk, pl, md);
    eser = we && !full && (ef == 2'd0);
    if (we && full) model = sf;
    else if (eser) model = exp_legacy(model, s16);
    @(negedge clk);
    check(tag, "ctl_reg", ctl_reg, model);
    check(tag, "prot_mode", {31'b0, prot_mode}, {31'b0, model[0]});
    check(tag, "serialize", {31'b0, serialize}, {31'b0, eser});
    check(tag, "fault_code", {30'b0, fault_code}, {30'b0, ef});
  endtask

  initial begin : watchdog
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", "ctl_reg", ctl_reg, 32'h0000_0010);
    check("R1", "prot_mode", {31'b0, prot_mode}, 32'd0);
    check("R1", "serialize", {31'b0, serialize}, 32'd0);
    check("R1", "fault_code", {30'b0, fault_code}, 32'd0);
    rst_n = 1'b1;
    step("R1", 1'b0, 1'b0, 16'h0, '0, 2'd0, 2'd0, 1'b0);

    // R2: upper operand bits ignored, upper register bits kept
    step("R5", 1'b1, 1'b1, 16'h0, 32'hA5A5_A5A0, 2'd3, 2'd1, 1'b1);
    step("R2", 1'b1, 1'b0, 16'hFFFE, '0, 2'd0, 2'd0, 1'b0);
    // R3: set protection enable in real mode, cpl ignored there (R6)
    step("R3", 1'b1, 1'b0, 16'h0001, '0, 2'd3, 2'd0, 1'b0);
    // R4: clear attempt keeps PE
    step("R4", 1'b1, 1'b0, 16'h0000, '0, 2'd0, 2'd1, 1'b0);
    // R10: fault code clears on idle
    step("R10", 1'b0, 1'b0, 16'h0, '0, 2'd0, 2'd1, 1'b0);
    // R6: privilege fault in v86 and 64-bit
    step("R6", 1'b1, 1'b0, 16'h000E, '0, 2'd3, 2'd2, 1'b0);
    step("R9", 1'b1, 1'b0, 16'h0000, '0, 2'd1, 2'd3, 1'b0);
    // R7: lock in real mode, and lock over privilege
    step("R7", 1'b1, 1'b0, 16'h000F, '0, 2'd0, 2'd0, 1'b1);
    step("R7", 1'b1, 1'b0, 16'h000F, '0, 2'd3, 2'd1, 1'b1);
    // R5: full move clears PE
    step("R5", 1'b1, 1'b1, 16'h0, 32'h8000_0012, 2'd0, 2'd1, 1'b0);
    // R8: back-to-back legacy loads pulse every cycle
    step("R8", 1'b1, 1'b0, 16'h0003, '0, 2'd0, 2'd0, 1'b0);
    step("R8", 1'b1, 1'b0, 16'h0004, '0, 2'd0, 2'd1, 1'b0);
    step("R8", 1'b0, 1'b0, 16'h0, '0, 2'd0, 2'd0, 1'b0);

    // Random phase (R2..R10)
    for (int i = 0; i < 3000; i++) begin
      logic we, full, lk;
      logic [1:0] pl, md;
      we   = ($urandom % 4) != 0;
      full = ($urandom % 5) == 0;
      lk   = ($urandom % 8) == 0;
      pl   = (($urandom % 2) == 0) ? 2'd0 : 2'($urandom);
      md   = 2'($urandom);
      step("R2-rand", we, full, 16'($urandom), $urandom, pl, md, lk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule